// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs the digital side of a 10-bit successive approximation conversion. A start request arrives as a one-cycle pulse on the serial clock. The block carries it across to a separate conversion clock, which runs all the time and has no fixed phase or frequency relation to the serial clock. Each accepted start opens a fixed frame of 41 conversion clock cycles. During the frame the block drives a trial code into an external comparator ladder. It reads back one decision bit per trial and builds the result from the most significant bit down.

The frame is one setup cycle followed by ten trials of four cycles each. The decision for a trial is taken on the last cycle of that trial. When the frame ends, the block does four things on the same clock edge: it drops the busy line, places the finished code on the result port, and pulses a load strobe for the downstream output shift register. It also sends a completion event back to the serial domain, where it appears as a one-cycle pulse. A start that arrives while a frame is running is dropped.

Top module: `sar_conv_ctrl`

## Requirements
- R1: At the end of a frame the result equals the highest code that the comparator reports as at or below the input level (cmpHigh = 1 means input >= trialCode). For a ladder whose input is an integer level V in 0..1023, the result is V.
- R2: In frame cycle 0, trialCode is 0. In frame cycles 1+4j to 4+4j (j = 0..9), trialCode holds the bits already decided above bit 9-j and has bit 9-j set, with all lower bits clear. The decision for bit 9-j uses cmpHigh in frame cycle 4+4j.
- R3: Each accepted start keeps busy high for exactly 41 consecutive conversion clock cycles.
- R4: resultLoad is a single-cycle pulse in the first cycle after busy falls. In that cycle result already carries the new code. resultLoad stays low while busy is high.
- R5: A one-cycle startReq pulse on sClk raises busy between 2 and 4 conversion clock edges after the sClk edge that samples it. The request crosses as a toggle through a two-flop synchronizer.
- R6: A start request that arrives while busy is high is ignored. No second frame follows.
- R7: Each completed frame produces exactly one doneEvt pulse, one sClk cycle wide, in the serial domain.
- R8: While idle, trialCode and result hold their values whatever cmpHigh does.
- R9: Synchronous resets (cRst on cClk, sRst on sClk, asserted together) clear busy, trialCode, result, resultLoad and doneEvt, including partway through a frame. After release no spurious frame starts.
- R10: Conversion and completion behave the same whether sClk is slower or faster than cClk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cClk | input | 1 | Conversion clock, free running |
| cRst | input | 1 | Synchronous reset, conversion domain |
| sClk | input | 1 | Serial clock |
| sRst | input | 1 | Synchronous reset, serial domain |
| startReq | input | 1 | One-cycle start request, serial domain |
| cmpHigh | input | 1 | Comparator decision: input at or above trialCode |
| trialCode | output | 10 | Trial code driving the ladder |
| busy | output | 1 | High for the 41-cycle conversion frame |
| result | output | 10 | Finished conversion code |
| resultLoad | output | 1 | One-cycle strobe loading result into the output shift register |
| doneEvt | output | 1 | One-cycle completion pulse, serial domain |

## Verification
The hardest case to reach is a second start request that crosses the synchronizer while a frame is already running. Only this case exercises the ignore path and checks that the toggle handshake does not leave a start pending. The stimulus times the second pulse from the frame cycle count and issues it at frame cycle 10. It does this with the serial clock both slower and faster than the conversion clock, and then watches an idle window that is longer than the crossing latency. A reset partway through a frame, with both toggle chains cleared together, covers the other way a start could go wrong.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // strobes from the frame sequencer to the code register
  typedef struct packed {
    logic clr;    // start accepted: clear trial code and bit pointer
    logic seed;   // setup cycle: place the top trial bit
    logic judge;  // last cycle of a trial: resolve the current bit
    logic load;   // final resolve: publish the code
  } strobe_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_handshake.sv
module sar_handshake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic cClk,
  input  logic cRst,
  input  logic sClk,
  input  logic sRst,
  input  logic startReq,
  input  logic doneIn,
  output logic startPulse,
  output logic doneEvt
);
  logic startTog, startSyncC, startPrev;
  logic doneTog, doneSyncS, donePrev;

  // serial side: each request flips a level
  always_ff @(posedge sClk) begin
    if (sRst)          startTog <= 1'b0;
    else if (startReq) startTog <= ~startTog;
  end

  sar_sync #(.STAGES(SYNC_STAGES)) u_startSync (
    .clk(cClk), .rst(cRst), .d(startTog), .q(startSyncC)
  );

  always_ff @(posedge cClk) begin
    if (cRst) begin
      startPrev <= 1'b0;
      doneTog   <= 1'b0;
    end else begin
      startPrev <= startSyncC;
      if (doneIn) doneTog <= ~doneTog;
    end
  end

  assign startPulse = startSyncC ^ startPrev;

  sar_sync #(.STAGES(SYNC_STAGES)) u_doneSync (
    .clk(sClk), .rst(sRst), .d(doneTog), .q(doneSyncS)
  );

  always_ff @(posedge sClk) begin
    if (sRst) begin
      donePrev <= 1'b0;
      doneEvt  <= 1'b0;
    end else begin
      donePrev <= doneSyncS;
      doneEvt  <= doneSyncS ^ donePrev;
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int TRIAL_CYC = 4
) (
  input  logic    cClk,
  input  logic    cRst,
  input  logic    startPulse,
  output logic    busy,
  output strobe_t stb
);
  localparam int FRAME = 1 + RES_W * TRIAL_CYC;
  localparam int CNT_W = $clog2(FRAME);
  localparam int PH_W  = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;

  logic [CNT_W-1:0] frameCnt;
  logic [PH_W-1:0]  phase;
  logic accept, lastCyc, trialEnd;

  always_comb begin
    accept    = startPulse && !busy;
    lastCyc   = busy && (frameCnt == CNT_W'(FRAME - 1));
    trialEnd  = busy && (frameCnt != '0) && (phase == PH_W'(TRIAL_CYC - 1));
    stb.clr   = accept;
    stb.seed  = busy && (frameCnt == '0);
    stb.judge = trialEnd;
    stb.load  = lastCyc;
  end

  always_ff @(posedge cClk) begin
    if (cRst) begin
      busy     <= 1'b0;
      frameCnt <= '0;
      phase    <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      frameCnt <= '0;
      phase    <= '0;
    end else if (busy) begin
      if (lastCyc) begin
        busy     <= 1'b0;
        frameCnt <= '0;
        phase    <= '0;
      end else begin
        frameCnt <= frameCnt + 1'b1;
        if (frameCnt != '0) phase <= trialEnd ? '0 : phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             cClk,
  input  logic             cRst,
  input  strobe_t          stb,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] result,
  output logic             resultLoad
);
  logic [RES_W-1:0] bitPtr, codeNx, ptrNx;

  always_comb begin
    codeNx = trialCode;
    ptrNx  = bitPtr;
    if (stb.clr) begin
      codeNx = '0;
      ptrNx  = '0;
    end else if (stb.seed) begin
      ptrNx  = {1'b1, {(RES_W-1){1'b0}}};
      codeNx = ptrNx;
    end else if (stb.judge) begin
      codeNx = (cmpHigh ? trialCode : (trialCode & ~bitPtr)) | (bitPtr >> 1);
      ptrNx  = bitPtr >> 1;
    end
  end

  always_ff @(posedge cClk) begin
    if (cRst) begin
      trialCode  <= '0;
      bitPtr     <= '0;
      result     <= '0;
      resultLoad <= 1'b0;
    end else begin
      trialCode  <= codeNx;
      bitPtr     <= ptrNx;
      resultLoad <= stb.load;
      if (stb.load) result <= codeNx;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int TRIAL_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             cClk,
  input  logic             cRst,
  input  logic             sClk,
  input  logic             sRst,
  input  logic             startReq,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] trialCode,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             resultLoad,
  output logic             doneEvt
);
  strobe_t stb;
  logic    startPulse;

  sar_handshake #(.SYNC_STAGES(SYNC_STAGES)) u_hs (
    .cClk(cClk), .cRst(cRst), .sClk(sClk), .sRst(sRst),
    .startReq(startReq), .doneIn(stb.load),
    .startPulse(startPulse), .doneEvt(doneEvt)
  );

  sar_ctrl #(.RES_W(RES_W), .TRIAL_CYC(TRIAL_CYC)) u_ctrl (
    .cClk(cClk), .cRst(cRst), .startPulse(startPulse),
    .busy(busy), .stb(stb)
  );

  sar_dpath #(.RES_W(RES_W)) u_dp (
    .cClk(cClk), .cRst(cRst), .stb(stb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .result(result), .resultLoad(resultLoad)
  );
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int RES_W     = 10,
  parameter int TRIAL_CYC = 4
) (
  input logic             cClk,
  input logic             cRst,
  input logic             sClk,
  input logic             sRst,
  input logic [RES_W-1:0] trialCode,
  input logic             busy,
  input logic [RES_W-1:0] result,
  input logic             resultLoad,
  input logic             doneEvt
);
  localparam int FRAME = 1 + RES_W * TRIAL_CYC;
  localparam int RUN_W = $clog2(FRAME) + 1;

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge cClk) begin
    if (cRst)      runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  a_r3_busy_len: assert property (@(posedge cClk) disable iff (cRst)
    ($fell(busy) && !$past(cRst)) |-> (runLen == RUN_W'(FRAME)));

  a_r4_load_after_busy: assert property (@(posedge cClk) disable iff (cRst)
    resultLoad |-> (!busy && $past(busy)));

  a_r4_result_hold: assert property (@(posedge cClk) disable iff (cRst)
    (!resultLoad && !$past(cRst)) |-> $stable(result));

  a_r2_setup_zero: assert property (@(posedge cClk) disable iff (cRst)
    $rose(busy) |-> (trialCode == '0));

  a_r8_idle_hold: assert property (@(posedge cClk) disable iff (cRst)
    (!busy && !$past(busy) && !$past(cRst)) |-> $stable(trialCode));

  a_r7_done_single: assert property (@(posedge sClk) disable iff (sRst)
    doneEvt |=> !doneEvt);
endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_W(RES_W), .TRIAL_CYC(TRIAL_CYC)) u_chk (
  .cClk(cClk), .cRst(cRst), .sClk(sClk), .sRst(sRst),
  .trialCode(trialCode), .busy(busy), .result(result),
  .resultLoad(resultLoad), .doneEvt(doneEvt)
);

// File: tb/tb_sar_conv_ctrl.sv
`timescale 1ns/100ps
module tb_sar_conv_ctrl;
  localparam int RW    = 10;
  localparam int TC    = 4;
  localparam int FRAME = 1 + RW * TC;

  logic cClk = 0, sClk = 0, cRst = 1, sRst = 1, startReq = 0;
  logic [RW-1:0] trialCode, result;
  logic busy, resultLoad, doneEvt, cmpHigh;
  int  analogIn = 0;
  real sHalf = 10.5;
  int  errors = 0, checks = 0, doneCnt = 0, cyc = 0;

  always #4 cClk = ~cClk;  // 125 MHz conversion clock
  always begin #(sHalf); sClk = ~sClk; end

  assign cmpHigh = (analogIn >= int'(trialCode));

  sar_conv_ctrl dut (
    .cClk(cClk), .cRst(cRst), .sClk(sClk), .sRst(sRst),
    .startReq(startReq), .cmpHigh(cmpHigh), .trialCode(trialCode),
    .busy(busy), .result(result), .resultLoad(resultLoad), .doneEvt(doneEvt)
  );

  always @(negedge sClk) if (doneEvt) doneCnt++;

  always @(posedge cClk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expTrial(int vin, int k);
    int j, b;
    if (k == 0) return 0;
    j = (k - 1) / TC;
    b = RW - 1 - j;
    return ((vin >> (b + 1)) << (b + 1)) | (1 << b);
  endfunction

  task automatic applyReset();
    cRst = 1; sRst = 1;
    repeat (8) @(negedge cClk);
    cRst = 0; sRst = 0;
    @(negedge cClk);
    chk("R9 busy after reset", busy, 0);
    chk("R9 trialCode after reset", trialCode, 0);
    chk("R9 result after reset", result, 0);
    chk("R9 resultLoad after reset", resultLoad, 0);
    chk("R9 doneEvt after reset", doneEvt, 0);
  endtask

  task automatic pulseStart();
    @(negedge sClk); startReq = 1;
    @(negedge sClk); startReq = 0;
  endtask

  task automatic convert(int vin, bit extra, string tag);
    int edges = 0;
    int d0 = doneCnt;
    analogIn = vin;
    @(negedge sClk); startReq = 1;
    @(posedge sClk);
    fork begin @(negedge sClk); startReq = 0; end join_none
    do begin
      @(posedge cClk); edges++;
      @(negedge cClk);
    end while (!busy && edges < 10);
    chk("R5 start latency in range", (edges >= 2 && edges <= 4) ? 1 : 0, 1);
    for (int k = 0; k < FRAME; k++) begin
      if (k > 0) @(negedge cClk);
      chk("R3 busy held in frame", busy, 1);
      chk("R2 trial code", int'(trialCode), expTrial(vin, k));
      chk("R4 no load while busy", resultLoad, 0);
      if (extra && k == 10) fork pulseStart(); join_none
    end
    @(negedge cClk);
    chk("R3 busy falls after 41", busy, 0);
    chk("R4 load strobe", resultLoad, 1);
    chk({tag, " R1 result"}, int'(result), vin);
    chk("R1 final trial code", int'(trialCode), vin);
    analogIn = 1023 - vin;  // comparator flips while idle
    for (int i = 0; i < 12; i++) begin
      @(negedge cClk);
      chk("R6 no further frame", busy, 0);
      chk("R4 load single cycle", resultLoad, 0);
      chk("R8 result held idle", int'(result), vin);
      chk("R8 trial held idle", int'(trialCode), vin);
    end
    repeat (6) @(negedge sClk);
    chk({tag, " R7 one done event"}, doneCnt - d0, 1);
  endtask

  initial begin
    int d0;
    applyReset();
    convert(0, 0, "R1");
    convert(1023, 0, "R1");
    convert(512, 0, "R1");
    convert(511, 1, "R6");
    convert(341, 0, "R1");
    convert(682, 0, "R1");
    convert(1, 1, "R6");
    // reset partway through a frame
    analogIn = 600;
    pulseStart();
    repeat (15) @(negedge cClk);
    chk("R9 frame running before reset", busy, 1);
    d0 = doneCnt;
    applyReset();
    for (int i = 0; i < 12; i++) begin
      @(negedge cClk);
      chk("R9 no spurious frame", busy, 0);
    end
    chk("R9 no done after reset", doneCnt - d0, 0);
    // serial clock faster than conversion clock
    sHalf = 2.5;
    repeat (4) @(negedge cClk);
    convert(777, 1, "R10");
    convert(3, 0, "R10");
    convert(1022, 1, "R10");
    sHalf = 10.5;
    repeat (4) @(negedge cClk);
    convert(200, 1, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule